// File: doc/BRIEF.md
# Pseudo-static RAM host-side strobe controller

This block sits between a synchronous host and a 1M x 16 pseudo-static memory that has an asynchronous SRAM-style pin set. Each host request (address, write data, per-byte enables, read/write flag) becomes one complete memory access. During that access the block drives an active-low chip select, output enable, write enable and two byte-lane strobes. The 16-bit data bus is shown as three signals: a driven value, a sampled value and a drive enable. Every interval in the access is a whole number of clock periods, worked out when the design is elaborated. Each nanosecond limit is divided by the clock-period parameter and rounded up.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle, so a request waits, holding its fields stable, until the previous access has fully recovered. There is no back-pressure on the response: `rsp_valid` is a single-cycle pulse and the host must take `rsp_rdata` in that cycle.

Each access goes through five phases: address setup, strobe-active window, standby hold, pad, idle. Together they keep the pseudo-static rules. Output enable is never low at the same time as write enable. Output enable stays high for a whole access whenever that access is a write. Strobes are held steady just after chip select rises. Write enable is high for a gap before any read asserts output enable. The address never changes inside the minimum cycle time.

Top module: `psram_host_ctrl`

## Requirements
- R1: `req_ready` is high exactly when no access is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the access has fully recovered. `rsp_valid` is high for one cycle per access.
- R2: With an 8 ns clock, `rsp_valid` rises 10 cycles after the accepting edge for a read and 7 cycles after it for a write. In general these are 1 + read window and 1 + write window.
- R3: Byte-enable bit 0 selects data bits 7..0 and drives lane strobe bit 0. Bit 1 selects bits 15..8 and drives lane strobe bit 1. On a read, a lane whose enable is 0 returns 8'h00 in `rsp_rdata`, and its strobe stays high.
- R4: A write changes only the enabled bytes. The other byte of the word keeps its earlier value when read back.
- R5: The write pulse (chip select and write enable both low) lasts at least 45 ns. The bus is driven in every cycle of that pulse.
- R6: Read data is sampled no earlier than 70 ns after chip select falls and no earlier than 45 ns after output enable falls.
- R7: Output enable and write enable are never low together, so output enable is already high when a write pulse starts.
- R8: The bus is driven only while chip select and write enable are both low. It is released at least one cycle before output enable falls.
- R9: When chip select rises, output enable and write enable keep their values for at least 10 ns. Chip select then stays high for at least 15 ns before it falls again.
- R10: Write enable stays high for at least 15 ns before output enable falls.
- R11: The address changes only while chip select is high. Two address changes are at least 80 ns apart.
- R12: Chip select is never held low for longer than 1000 ns.
- R13: After reset, `req_ready` is high, all strobes are high, the bus is released and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_ben | input | 2 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle access-done pulse |
| rsp_rdata | output | 16 | Read data, masked bytes zero |
| mem_addr | output | 20 | Memory address |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Byte lane strobes, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Value driven onto the data bus |
| mem_dq_in | input | 16 | Value sampled from the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
The embedded properties assume that the host holds request fields stable while `req_valid` is high and `req_ready` is low. They also assume the memory puts valid data on the bus only once its access time has passed. The bench's memory model does exactly that: it returns a garbage pattern until the access time has elapsed, and a garbage pattern on disabled lanes. This lets early sampling or missing lane masking show up as a data mismatch. All host inputs change only on falling clock edges. A request is dropped on the falling edge after it is accepted, so the stimulus never breaks the handshake that the properties take for granted.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_HOLD,
    ST_PAD
  } seq_st_t;

  // round a nanosecond limit up to whole clock periods
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_seq.sv
module psram_seq
  import psram_ctrl_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int RD_C     = 9,
  parameter int WR_C     = 6,
  parameter int HOLD_C   = 2,
  parameter int PAD_C    = 2,
  parameter int MAXLOW_C = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  input  logic [LANES-1:0] ben_q,
  input  logic [19:0]      mem_addr,
  output logic             mem_ce1_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic [LANES-1:0] mem_lane_n,
  output logic             mem_dq_oe,
  output logic             rsp_valid
);

  localparam int CNT_MAX = imax(imax(RD_C, WR_C), imax(HOLD_C, PAD_C));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int LO_W    = $clog2(MAXLOW_C + 2);

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;
  logic             rsp_q;
  logic             cnt_zero;
  logic             in_act;
  logic             strobe_win;

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign cnt_zero   = (cnt == '0);
  assign in_act     = (st == ST_ACT);
  assign strobe_win = in_act || (st == ST_HOLD);
  assign capture    = in_act && cnt_zero && !wr_q;
  assign rsp_valid  = rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
      rsp_q <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (accept) begin
            st   <= ST_SETUP;
            wr_q <= req_write;
          end
        end
        ST_SETUP: begin
          st  <= ST_ACT;
          cnt <= wr_q ? CNT_W'(WR_C - 1) : CNT_W'(RD_C - 1);
        end
        ST_ACT: begin
          if (cnt_zero) begin
            st    <= ST_HOLD;
            cnt   <= CNT_W'(HOLD_C - 1);
            rsp_q <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt_zero) begin
            st  <= ST_PAD;
            cnt <= CNT_W'(PAD_C - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PAD: begin
          if (cnt_zero) st <= ST_IDLE;
          else          cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // strobes: chip select only in the active window, OE/WE/lanes kept
  // through the standby hold so they stay put after chip select rises
  assign mem_ce1_n  = !in_act;
  assign mem_oe_n   = !(strobe_win && !wr_q);
  assign mem_we_n   = !(strobe_win && wr_q);
  assign mem_dq_oe  = in_act && wr_q;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign mem_lane_n[gi] = !(strobe_win && ben_q[gi]);
    end
  endgenerate

  // run length of chip select low, watched by the checker below
  logic [LO_W-1:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lo_run <= '0;
    else if (!mem_ce1_n) lo_run <= (lo_run == '1) ? lo_run : lo_run + 1'b1;
    else                 lo_run <= '0;
  end

  // R7
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R8
  bus_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_ce1_n && !mem_we_n && mem_oe_n));

  // R9
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce1_n) |-> ($stable(mem_oe_n) && $stable(mem_we_n)));

  // R11
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

  // R12
  ce_low_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run <= LO_W'(MAXLOW_C));

  // R1
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

// File: rtl/psram_dpath.sv
module psram_dpath #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic                  capture,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_ben,
  input  logic [DATA_W-1:0]     mem_dq_in,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_dq_out,
  output logic [DATA_W/8-1:0]   ben_q,
  output logic [DATA_W-1:0]     rsp_rdata
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      ben_q   <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      ben_q   <= req_ben;
    end
  end

  genvar gl;
  generate
    for (gl = 0; gl < LANES; gl++) begin : g_rd_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q[8*gl +: 8] <= '0;
        else if (capture) rdata_q[8*gl +: 8] <= ben_q[gl] ? mem_dq_in[8*gl +: 8] : 8'h00;
      end

      // R3
      masked_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (ben_q[gl] || (rsp_rdata[8*gl +: 8] == 8'h00)));
    end
  endgenerate

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/psram_host_ctrl.sv
module psram_host_ctrl
  import psram_ctrl_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int DATA_W       = 16,
  parameter int CLK_NS       = 8,
  parameter int T_CYC_NS     = 80,
  parameter int T_CE_MAX_NS  = 1000,
  parameter int T_ACC_NS     = 70,
  parameter int T_OE_ACC_NS  = 45,
  parameter int T_WP_NS      = 45,
  parameter int T_DS_NS      = 20,
  parameter int T_WHOL_NS    = 15,
  parameter int T_CP_NS      = 15,
  parameter int T_HOLD_NS    = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_ben,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce1_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_lane_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  input  logic [DATA_W-1:0]   mem_dq_in,
  output logic                mem_dq_oe
);

  localparam int LANES    = DATA_W / 8;
  localparam int RD_C     = imax(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_OE_ACC_NS, CLK_NS));
  localparam int WR_C     = imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS));
  localparam int HOLD_C   = imax(1, ns_to_cyc(T_HOLD_NS, CLK_NS));
  localparam int CYC_C    = ns_to_cyc(T_CYC_NS, CLK_NS);
  localparam int REM_C    = CYC_C - 1 - imin(RD_C, WR_C) - HOLD_C;
  localparam int PAD_C    = imax(imax(1, ns_to_cyc(T_WHOL_NS, CLK_NS)),
                                 imax(ns_to_cyc(T_CP_NS, CLK_NS) - HOLD_C, REM_C));
  localparam int MAXLOW_C = T_CE_MAX_NS / CLK_NS;

  logic             accept;
  logic             capture;
  logic [LANES-1:0] ben_q;

  psram_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .capture    (capture),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ben    (req_ben),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .ben_q      (ben_q),
    .rsp_rdata  (rsp_rdata)
  );

  psram_seq #(
    .LANES    (LANES),
    .RD_C     (RD_C),
    .WR_C     (WR_C),
    .HOLD_C   (HOLD_C),
    .PAD_C    (PAD_C),
    .MAXLOW_C (MAXLOW_C)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .accept     (accept),
    .capture    (capture),
    .ben_q      (ben_q),
    .mem_addr   (mem_addr[19:0]),
    .mem_ce1_n  (mem_ce1_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_lane_n (mem_lane_n),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_valid  (rsp_valid)
  );

endmodule

// File: tb/psram_host_ctrl_tb.sv
module psram_host_ctrl_tb;

  localparam int CLK_NS   = 8;
  localparam int RD_EXP   = ((70 + CLK_NS - 1) / CLK_NS > (45 + CLK_NS - 1) / CLK_NS) ?
                            (70 + CLK_NS - 1) / CLK_NS : (45 + CLK_NS - 1) / CLK_NS;
  localparam int WR_EXP   = (45 + CLK_NS - 1) / CLK_NS;
  localparam int HOLD_EXP = (10 + CLK_NS - 1) / CLK_NS;
  localparam int GAP_EXP  = (15 + CLK_NS - 1) / CLK_NS;
  localparam int CYC_EXP  = (80 + CLK_NS - 1) / CLK_NS;
  localparam int LOW_EXP  = 1000 / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_ben = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_ce1_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  psram_host_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ben(req_ben),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // ---------------- behavioural memory model ----------------
  logic [15:0] mdl [logic [19:0]];
  logic [15:0] rd_word;
  int rd_cnt, wp_cnt, lo_cnt, ce_hi, we_hi, addr_age;
  logic p_ce, p_oe, p_we, p_dq_oe, p_pulse;
  logic [19:0] p_addr;
  logic [15:0] w_last;
  logic [1:0]  l_last;
  int v_r5, v_r6, v_r7, v_r8, v_r9, v_r10, v_r11, v_r12;

  function automatic logic [15:0] mdl_rd(input logic [19:0] a);
    return mdl.exists(a) ? mdl[a] : 16'h0000;
  endfunction

  always @* begin
    for (int i = 0; i < 2; i++)
      mem_dq_in[8*i +: 8] = (!mem_ce1_n && !mem_oe_n && !mem_lane_n[i] && rd_cnt >= RD_EXP - 1)
                            ? rd_word[8*i +: 8] : 8'hEE;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt = 0; wp_cnt = 0; lo_cnt = 0; ce_hi = 1000; we_hi = 1000; addr_age = 1000;
      p_ce = 1; p_oe = 1; p_we = 1; p_dq_oe = 0; p_pulse = 0; p_addr = mem_addr;
      w_last = '0; l_last = '1;
    end else begin
      if (!mem_oe_n && !mem_we_n) v_r7++;
      if (mem_dq_oe && (mem_ce1_n || mem_we_n || !mem_oe_n)) v_r8++;
      if (!mem_oe_n && p_oe && p_dq_oe) v_r8++;
      if (!mem_oe_n && p_oe && we_hi < GAP_EXP) v_r10++;
      if (mem_ce1_n && ce_hi < HOLD_EXP && (mem_oe_n != p_oe || mem_we_n != p_we)) v_r9++;
      if (!mem_ce1_n && p_ce && ce_hi < GAP_EXP) v_r9++;
      if (mem_addr != p_addr) begin
        if (!mem_ce1_n && !p_ce) v_r11++;
        if (addr_age < CYC_EXP) v_r11++;
        addr_age = 1;
      end else if (addr_age < 1000) addr_age++;
      // read window
      if (!mem_ce1_n && !mem_oe_n) begin
        rd_cnt++;
        rd_word = mdl_rd(mem_addr);
      end else rd_cnt = 0;
      // write pulse
      if (!mem_ce1_n && !mem_we_n) begin
        wp_cnt++;
        if (!mem_dq_oe) v_r5++;
        w_last = mem_dq_out;
        l_last = mem_lane_n;
        p_pulse = 1;
      end else if (p_pulse) begin
        if (wp_cnt < WR_EXP) v_r5++;
        begin
          logic [15:0] cur;
          cur = mdl_rd(mem_addr);
          for (int i = 0; i < 2; i++)
            if (!l_last[i]) cur[8*i +: 8] = w_last[8*i +: 8];
          mdl[mem_addr] = cur;
        end
        wp_cnt = 0;
        p_pulse = 0;
      end
      if (!mem_ce1_n) begin lo_cnt++; ce_hi = 0; end
      else begin lo_cnt = 0; if (ce_hi < 1000) ce_hi++; end
      if (lo_cnt > LOW_EXP) v_r12++;
      if (!mem_we_n) we_hi = 0; else if (we_hi < 1000) we_hi++;
      p_ce = mem_ce1_n; p_oe = mem_oe_n; p_we = mem_we_n; p_dq_oe = mem_dq_oe; p_addr = mem_addr;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [19:0] a, input logic [15:0] d,
                       input logic [1:0] be, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_ben = be;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R1: no second acceptance while the access runs
    chk(!req_ready, "R1", 32'(req_ready), 32'd0);
    lat = 0;
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    chk(!req_ready, "R1", 32'(req_ready), 32'd0);
  endtask

  function automatic logic [15:0] pat(input logic [19:0] a, input int b, input int s);
    return 16'((32'(a) * 13 + b * 32'h1111 + s * 32'h0F0F) ^ 32'h5A3C);
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] rd, shadow, nw;
    int lat;
    v_r5 = 0; v_r6 = 0; v_r7 = 0; v_r8 = 0; v_r9 = 0; v_r10 = 0; v_r11 = 0; v_r12 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R13 reset state
    chk(req_ready && mem_ce1_n && mem_oe_n && mem_we_n && mem_lane_n == 2'b11 && !mem_dq_oe && !rsp_valid,
        "R13", {25'd0, req_ready, mem_ce1_n, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe},
        {25'd0, 7'b1111110});

    for (int k = 0; k < 12; k++) begin
      logic [19:0] a;
      a = (k < 10) ? (20'h1 << (2 * k)) : ((k == 10) ? 20'h00000 : 20'hFFFFF);
      for (int b = 0; b < 4; b++) begin
        shadow = pat(a, b, 0);
        do_op(1'b1, a, shadow, 2'b11, rd, lat);
        chk(lat == 1 + WR_EXP, "R2", 32'(lat), 32'(1 + WR_EXP));
        nw = pat(a, b, 1);
        do_op(1'b1, a, nw, 2'(b), rd, lat);
        chk(lat == 1 + WR_EXP, "R2", 32'(lat), 32'(1 + WR_EXP));
        shadow = (shadow & ~lane_mask(2'(b))) | (nw & lane_mask(2'(b)));
        for (int rb = 0; rb < 4; rb++) begin
          do_op(1'b0, a, 16'h0000, 2'(rb), rd, lat);
          chk(lat == 1 + RD_EXP, "R2", 32'(lat), 32'(1 + RD_EXP));
          if (rb == 3)
            chk(rd == shadow, "R4", 32'(rd), 32'(shadow));
          else
            chk(rd == (shadow & lane_mask(2'(rb))), "R3", 32'(rd), 32'(shadow & lane_mask(2'(rb))));
        end
      end
    end
    // R6: full reads above return model data only if sampled after the access time
    chk(v_r5 == 0, "R5", 32'(v_r5), 32'd0);
    chk(v_r6 == 0, "R6", 32'(v_r6), 32'd0);
    chk(v_r7 == 0, "R7", 32'(v_r7), 32'd0);
    chk(v_r8 == 0, "R8", 32'(v_r8), 32'd0);
    chk(v_r9 == 0, "R9", 32'(v_r9), 32'd0);
    chk(v_r10 == 0, "R10", 32'(v_r10), 32'd0);
    chk(v_r11 == 0, "R11", 32'(v_r11), 32'd0);
    chk(v_r12 == 0, "R12", 32'(v_r12), 32'd0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule